// File: doc/BRIEF.md
# Dual-Destination Operand Forwarding Selector

This block picks the operand values that a five-stage pipeline actually uses when an older instruction has produced a register result that has not yet reached the register file. Every instruction in the pipeline may write up to two registers: a low result, written by ordinary instructions, and a high result, written only by multiply. The two stages behind execute, EX/MEM and MEM/WB, therefore each offer two write ports that have to be searched.

For the execute stage, the block looks at the source operand and the destination operand separately. For each one it chooses among the register-file value, the two EX/MEM results and the two MEM/WB results, following a fixed priority. For the memory stage, it chooses the store data and the store or load address. Each of these is either the value carried down the pipeline or one of the two MEM/WB write-back results.

The block is purely combinational and has no clock or reset. The pipeline registers around it are owned by the surrounding datapath. Each operand is reported as a select code together with the chosen 16-bit value.

Top module: `fwd_dual_dest_unit`

## Requirements
- R1: An execute operand whose index equals `exm_lo_idx` while `exm_lo_we` is 1 gets select 1 and the value `exm_lo_data`, regardless of any other port.
- R2: Failing R1, an execute operand matching `exm_hi_idx` with `exm_hi_we` set gets select 2 and `exm_hi_data`.
- R3: Failing R1 and R2, an execute operand matching `wb_lo_idx` with `wb_lo_we` set gets select 3 and `wb_lo_data`.
- R4: Failing R1 to R3, an execute operand matching `wb_hi_idx` with `wb_hi_we` set gets select 4 and `wb_hi_data`.
- R5: An execute operand with no match gets select 0 and its own register-file input (`ex_src_rf` or `ex_dst_rf`).
- R6: A port whose write enable is 0 never forwards, even when its index equals the operand index.
- R7: The source operand and the destination operand are resolved independently. Each may take a different select in the same cycle.
- R8: Store data compares `mem_dst_idx` against the MEM/WB ports. A low match gives select 1 and `wb_lo_data`. Otherwise a high match gives select 2 and `wb_hi_data`. Otherwise the select is 0 and the value is `mem_store_in`.
- R9: The memory address compares `mem_src_idx` in the same low-then-high order. The selects are 1 and 2, and the value falls back to `mem_addr_in` with select 0.
- R10: MEM/WB matches depend only on the MEM/WB indices; the EX/MEM indices play no part in them.
- R11: Register index 0 is an ordinary register and forwards like any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_idx | input | 3 | Execute-stage source register index |
| ex_dst_idx | input | 3 | Execute-stage destination register index |
| ex_src_rf | input | 16 | Source value read from the register file |
| ex_dst_rf | input | 16 | Destination value read from the register file |
| exm_lo_we | input | 1 | EX/MEM low write enable |
| exm_lo_idx | input | 3 | EX/MEM low destination index |
| exm_lo_data | input | 16 | EX/MEM low result |
| exm_hi_we | input | 1 | EX/MEM high write enable (multiply only) |
| exm_hi_idx | input | 3 | EX/MEM high destination index |
| exm_hi_data | input | 16 | EX/MEM high result |
| wb_lo_we | input | 1 | MEM/WB low write enable |
| wb_lo_idx | input | 3 | MEM/WB low destination index |
| wb_lo_data | input | 16 | MEM/WB low write-back value |
| wb_hi_we | input | 1 | MEM/WB high write enable |
| wb_hi_idx | input | 3 | MEM/WB high destination index |
| wb_hi_data | input | 16 | MEM/WB high write-back value |
| mem_dst_idx | input | 3 | Memory-stage destination register index (store data) |
| mem_src_idx | input | 3 | Memory-stage source register index (address) |
| mem_store_in | input | 16 | Store data carried down the pipeline |
| mem_addr_in | input | 16 | Address carried down the pipeline |
| ex_src_sel | output | 3 | Source operand select (0 file, 1 EX/MEM low, 2 EX/MEM high, 3 MEM/WB low, 4 MEM/WB high) |
| ex_src_val | output | 16 | Forwarded source operand |
| ex_dst_sel | output | 3 | Destination operand select, same coding |
| ex_dst_val | output | 16 | Forwarded destination operand |
| mem_data_sel | output | 2 | Store data select (0 path, 1 MEM/WB low, 2 MEM/WB high) |
| mem_data_val | output | 16 | Forwarded store data |
| mem_addr_sel | output | 2 | Address select, same coding |
| mem_addr_val | output | 16 | Forwarded address |

## Verification
The block holds no state, so a fault can only show up as a wrong select code or wrong value. It appears in the same cycle that the offending pattern is applied. A broken priority chain shows up only when two ports match at once. For this reason the stimulus deliberately makes several ports match the same index and then disables them one at a time. A mux that disagrees with its select, or a match made against the wrong stage's index, shows up as a select/value pair that does not fit the inputs. Long random runs over a small index space then make such collisions frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [2:0] {
    EX_SEL_RF     = 3'd0,
    EX_SEL_EXM_LO = 3'd1,
    EX_SEL_EXM_HI = 3'd2,
    EX_SEL_WB_LO  = 3'd3,
    EX_SEL_WB_HI  = 3'd4
  } ex_sel_e;

  typedef enum logic [1:0] {
    MEM_SEL_PATH  = 2'd0,
    MEM_SEL_WB_LO = 2'd1,
    MEM_SEL_WB_HI = 2'd2
  } mem_sel_e;

  localparam int unsigned EX_PORTS  = 4;
  localparam int unsigned MEM_PORTS = 2;

endpackage

// File: rtl/fwd_prio_pick.sv
module fwd_prio_pick #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned NPORTS = 4,
  localparam int unsigned SEL_W = $clog2(NPORTS + 1)
) (
  input  logic [IDX_W-1:0]             op_idx,
  input  logic [NPORTS-1:0]            port_we,
  input  logic [NPORTS-1:0][IDX_W-1:0] port_idx,
  output logic [SEL_W-1:0]             sel
);

  logic [NPORTS-1:0] hit;

  for (genvar k = 0; k < NPORTS; k++) begin : g_hit
    assign hit[k] = port_we[k] && (port_idx[k] == op_idx);
  end

  // Port 0 is the highest priority: scan from the lowest priority upward.
  always_comb begin
    sel = '0;
    for (int k = NPORTS - 1; k >= 0; k--) begin
      if (hit[k]) sel = SEL_W'(k + 1);
    end
  end

endmodule

// File: rtl/fwd_val_mux.sv
module fwd_val_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NPORTS = 4,
  localparam int unsigned SEL_W = $clog2(NPORTS + 1)
) (
  input  logic [SEL_W-1:0]              sel,
  input  logic [DATA_W-1:0]             fallback,
  input  logic [NPORTS-1:0][DATA_W-1:0] port_data,
  output logic [DATA_W-1:0]             val
);

  always_comb begin
    val = fallback;
    for (int k = 0; k < NPORTS; k++) begin
      if (sel == SEL_W'(k + 1)) val = port_data[k];
    end
  end

endmodule

// File: rtl/fwd_dual_dest_unit.sv
module fwd_dual_dest_unit
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned EX_SEL_W  = $clog2(EX_PORTS + 1),
  localparam int unsigned MEM_SEL_W = $clog2(MEM_PORTS + 1)
) (
  input  logic [IDX_W-1:0]     ex_src_idx,
  input  logic [IDX_W-1:0]     ex_dst_idx,
  input  logic [DATA_W-1:0]    ex_src_rf,
  input  logic [DATA_W-1:0]    ex_dst_rf,
  input  logic                 exm_lo_we,
  input  logic [IDX_W-1:0]     exm_lo_idx,
  input  logic [DATA_W-1:0]    exm_lo_data,
  input  logic                 exm_hi_we,
  input  logic [IDX_W-1:0]     exm_hi_idx,
  input  logic [DATA_W-1:0]    exm_hi_data,
  input  logic                 wb_lo_we,
  input  logic [IDX_W-1:0]     wb_lo_idx,
  input  logic [DATA_W-1:0]    wb_lo_data,
  input  logic                 wb_hi_we,
  input  logic [IDX_W-1:0]     wb_hi_idx,
  input  logic [DATA_W-1:0]    wb_hi_data,
  input  logic [IDX_W-1:0]     mem_dst_idx,
  input  logic [IDX_W-1:0]     mem_src_idx,
  input  logic [DATA_W-1:0]    mem_store_in,
  input  logic [DATA_W-1:0]    mem_addr_in,
  output logic [EX_SEL_W-1:0]  ex_src_sel,
  output logic [DATA_W-1:0]    ex_src_val,
  output logic [EX_SEL_W-1:0]  ex_dst_sel,
  output logic [DATA_W-1:0]    ex_dst_val,
  output logic [MEM_SEL_W-1:0] mem_data_sel,
  output logic [DATA_W-1:0]    mem_data_val,
  output logic [MEM_SEL_W-1:0] mem_addr_sel,
  output logic [DATA_W-1:0]    mem_addr_val
);

  localparam int unsigned EX_OPS  = 2;  // 0: source, 1: destination
  localparam int unsigned MEM_OPS = 2;  // 0: store data, 1: address

  // Execute-stage port tables, ordered by priority.
  logic [EX_PORTS-1:0]             ex_we;
  logic [EX_PORTS-1:0][IDX_W-1:0]  ex_idx;
  logic [EX_PORTS-1:0][DATA_W-1:0] ex_data;
  assign ex_we   = {wb_hi_we,   wb_lo_we,   exm_hi_we,   exm_lo_we};
  assign ex_idx  = {wb_hi_idx,  wb_lo_idx,  exm_hi_idx,  exm_lo_idx};
  assign ex_data = {wb_hi_data, wb_lo_data, exm_hi_data, exm_lo_data};

  // Memory-stage port tables: MEM/WB only, low first.
  logic [MEM_PORTS-1:0]             wb_we;
  logic [MEM_PORTS-1:0][IDX_W-1:0]  wb_idx;
  logic [MEM_PORTS-1:0][DATA_W-1:0] wb_data;
  assign wb_we   = {wb_hi_we,   wb_lo_we};
  assign wb_idx  = {wb_hi_idx,  wb_lo_idx};
  assign wb_data = {wb_hi_data, wb_lo_data};

  logic [EX_OPS-1:0][IDX_W-1:0]     ex_op_idx;
  logic [EX_OPS-1:0][DATA_W-1:0]    ex_op_rf;
  logic [EX_OPS-1:0][EX_SEL_W-1:0]  ex_op_sel;
  logic [EX_OPS-1:0][DATA_W-1:0]    ex_op_val;
  assign ex_op_idx = {ex_dst_idx, ex_src_idx};
  assign ex_op_rf  = {ex_dst_rf,  ex_src_rf};

  logic [MEM_OPS-1:0][IDX_W-1:0]     mem_op_idx;
  logic [MEM_OPS-1:0][DATA_W-1:0]    mem_op_path;
  logic [MEM_OPS-1:0][MEM_SEL_W-1:0] mem_op_sel;
  logic [MEM_OPS-1:0][DATA_W-1:0]    mem_op_val;
  assign mem_op_idx  = {mem_src_idx, mem_dst_idx};
  assign mem_op_path = {mem_addr_in, mem_store_in};

  for (genvar o = 0; o < EX_OPS; o++) begin : g_ex_op
    fwd_prio_pick #(.IDX_W(IDX_W), .NPORTS(EX_PORTS)) u_pick (
      .op_idx   (ex_op_idx[o]),
      .port_we  (ex_we),
      .port_idx (ex_idx),
      .sel      (ex_op_sel[o])
    );
    fwd_val_mux #(.DATA_W(DATA_W), .NPORTS(EX_PORTS)) u_mux (
      .sel       (ex_op_sel[o]),
      .fallback  (ex_op_rf[o]),
      .port_data (ex_data),
      .val       (ex_op_val[o])
    );
  end

  for (genvar o = 0; o < MEM_OPS; o++) begin : g_mem_op
    fwd_prio_pick #(.IDX_W(IDX_W), .NPORTS(MEM_PORTS)) u_pick (
      .op_idx   (mem_op_idx[o]),
      .port_we  (wb_we),
      .port_idx (wb_idx),
      .sel      (mem_op_sel[o])
    );
    fwd_val_mux #(.DATA_W(DATA_W), .NPORTS(MEM_PORTS)) u_mux (
      .sel       (mem_op_sel[o]),
      .fallback  (mem_op_path[o]),
      .port_data (wb_data),
      .val       (mem_op_val[o])
    );
  end

  assign ex_src_sel   = ex_op_sel[0];
  assign ex_src_val   = ex_op_val[0];
  assign ex_dst_sel   = ex_op_sel[1];
  assign ex_dst_val   = ex_op_val[1];
  assign mem_data_sel = mem_op_sel[0];
  assign mem_data_val = mem_op_val[0];
  assign mem_addr_sel = mem_op_sel[1];
  assign mem_addr_val = mem_op_val[1];

  // Cross-checks between the picker outputs, the mux outputs and the ports.
  always_comb begin
    if (ex_src_sel == EX_SEL_EXM_LO) begin
      assert_exm_lo_pick_R1: assert (exm_lo_we && exm_lo_idx == ex_src_idx
                                     && ex_src_val == exm_lo_data)
        else $error("EX/MEM low pick inconsistent");
    end
    if (ex_src_sel == EX_SEL_EXM_HI) begin
      assert_exm_hi_pick_R2: assert (exm_hi_we && exm_hi_idx == ex_src_idx
                                     && !(exm_lo_we && exm_lo_idx == ex_src_idx)
                                     && ex_src_val == exm_hi_data)
        else $error("EX/MEM high pick inconsistent");
    end
    if (ex_src_sel == EX_SEL_WB_LO) begin
      assert_wb_lo_pick_R3: assert (wb_lo_we && wb_lo_idx == ex_src_idx
                                    && !(exm_hi_we && exm_hi_idx == ex_src_idx)
                                    && ex_src_val == wb_lo_data)
        else $error("MEM/WB low pick inconsistent");
    end
    if (ex_dst_sel == EX_SEL_WB_HI) begin
      assert_wb_hi_pick_R4: assert (wb_hi_we && wb_hi_idx == ex_dst_idx
                                    && !(wb_lo_we && wb_lo_idx == ex_dst_idx)
                                    && ex_dst_val == wb_hi_data)
        else $error("MEM/WB high pick inconsistent");
    end
    if (!exm_lo_we && !exm_hi_we && !wb_lo_we && !wb_hi_we) begin
      assert_idle_passthru_R6: assert (ex_src_sel == EX_SEL_RF && ex_dst_sel == EX_SEL_RF
                                       && ex_src_val == ex_src_rf && ex_dst_val == ex_dst_rf)
        else $error("forward without any write enable");
    end
    if (mem_data_sel == MEM_SEL_WB_HI) begin
      assert_store_hi_pick_R8: assert (!(wb_lo_we && wb_lo_idx == mem_dst_idx)
                                       && mem_data_val == wb_hi_data)
        else $error("store data high pick inconsistent");
    end
    if (mem_addr_sel == MEM_SEL_PATH) begin
      assert_addr_path_R9: assert (mem_addr_val == mem_addr_in)
        else $error("address fallback inconsistent");
    end
  end

endmodule

// File: tb/fwd_dual_dest_unit_tb.sv
module fwd_dual_dest_unit_tb;

  localparam int unsigned IW = 3;
  localparam int unsigned DW = 16;

  typedef struct packed {
    logic [IW-1:0] src_idx, dst_idx;
    logic [DW-1:0] src_rf, dst_rf;
    logic          el_we;  logic [IW-1:0] el_idx; logic [DW-1:0] el_d;
    logic          eh_we;  logic [IW-1:0] eh_idx; logic [DW-1:0] eh_d;
    logic          wl_we;  logic [IW-1:0] wl_idx; logic [DW-1:0] wl_d;
    logic          wh_we;  logic [IW-1:0] wh_idx; logic [DW-1:0] wh_d;
    logic [IW-1:0] md_idx, ma_idx;
    logic [DW-1:0] m_store, m_addr;
  } stim_t;

  typedef struct {
    logic [2:0]  s_sel; logic [DW-1:0] s_val;
    logic [2:0]  d_sel; logic [DW-1:0] d_val;
    logic [1:0]  md_sel; logic [DW-1:0] md_val;
    logic [1:0]  ma_sel; logic [DW-1:0] ma_val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  stim_t st;
  logic [2:0]  ex_src_sel, ex_dst_sel;
  logic [1:0]  mem_data_sel, mem_addr_sel;
  logic [DW-1:0] ex_src_val, ex_dst_val, mem_data_val, mem_addr_val;

  fwd_dual_dest_unit u_dut (
    .ex_src_idx(st.src_idx), .ex_dst_idx(st.dst_idx),
    .ex_src_rf(st.src_rf), .ex_dst_rf(st.dst_rf),
    .exm_lo_we(st.el_we), .exm_lo_idx(st.el_idx), .exm_lo_data(st.el_d),
    .exm_hi_we(st.eh_we), .exm_hi_idx(st.eh_idx), .exm_hi_data(st.eh_d),
    .wb_lo_we(st.wl_we), .wb_lo_idx(st.wl_idx), .wb_lo_data(st.wl_d),
    .wb_hi_we(st.wh_we), .wb_hi_idx(st.wh_idx), .wb_hi_data(st.wh_d),
    .mem_dst_idx(st.md_idx), .mem_src_idx(st.ma_idx),
    .mem_store_in(st.m_store), .mem_addr_in(st.m_addr),
    .ex_src_sel(ex_src_sel), .ex_src_val(ex_src_val),
    .ex_dst_sel(ex_dst_sel), .ex_dst_val(ex_dst_val),
    .mem_data_sel(mem_data_sel), .mem_data_val(mem_data_val),
    .mem_addr_sel(mem_addr_sel), .mem_addr_val(mem_addr_val)
  );

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected selection per requirement R1..R5 (execute), R8/R9 (memory).
  function automatic logic [2:0] ex_expect(stim_t s, logic [IW-1:0] i);
    if (s.el_we && s.el_idx == i) return 3'd1;
    if (s.eh_we && s.eh_idx == i) return 3'd2;
    if (s.wl_we && s.wl_idx == i) return 3'd3;
    if (s.wh_we && s.wh_idx == i) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [DW-1:0] ex_value(stim_t s, logic [2:0] k, logic [DW-1:0] rf);
    case (k)
      3'd1: return s.el_d;
      3'd2: return s.eh_d;
      3'd3: return s.wl_d;
      3'd4: return s.wh_d;
      default: return rf;
    endcase
  endfunction

  function automatic logic [1:0] mem_expect(stim_t s, logic [IW-1:0] i);
    if (s.wl_we && s.wl_idx == i) return 2'd1;
    if (s.wh_we && s.wh_idx == i) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [DW-1:0] mem_value(stim_t s, logic [1:0] k, logic [DW-1:0] p);
    if (k == 2'd1) return s.wl_d;
    if (k == 2'd2) return s.wh_d;
    return p;
  endfunction

  // Driver: apply on the falling edge, queue the expectation.
  task automatic drive(stim_t s, string tag,
                       int xs = -1, int xd = -1, int xm = -1, int xa = -1);
    exp_t e;
    @(negedge clk);
    st = s;
    e.s_sel  = ex_expect(s, s.src_idx);
    e.d_sel  = ex_expect(s, s.dst_idx);
    e.md_sel = mem_expect(s, s.md_idx);
    e.ma_sel = mem_expect(s, s.ma_idx);
    // Directed tests also pin the select they were written for.
    if (xs >= 0 && e.s_sel  != 3'(xs)) $display("bench note: model/plan disagree on %s", tag);
    if (xs >= 0) e.s_sel  = 3'(xs);
    if (xd >= 0) e.d_sel  = 3'(xd);
    if (xm >= 0) e.md_sel = 2'(xm);
    if (xa >= 0) e.ma_sel = 2'(xa);
    e.s_val  = ex_value(s, e.s_sel, s.src_rf);
    e.d_val  = ex_value(s, e.d_sel, s.dst_rf);
    e.md_val = mem_value(s, e.md_sel, s.m_store);
    e.ma_val = mem_value(s, e.ma_sel, s.m_addr);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: rising edge, half a period after the driver.
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "ex_src_sel",   DW'(ex_src_sel),   DW'(e.s_sel));
      cmp(e.tag, "ex_src_val",   ex_src_val,        e.s_val);
      cmp(e.tag, "ex_dst_sel",   DW'(ex_dst_sel),   DW'(e.d_sel));
      cmp(e.tag, "ex_dst_val",   ex_dst_val,        e.d_val);
      cmp(e.tag, "mem_data_sel", DW'(mem_data_sel), DW'(e.md_sel));
      cmp(e.tag, "mem_data_val", mem_data_val,      e.md_val);
      cmp(e.tag, "mem_addr_sel", DW'(mem_addr_sel), DW'(e.ma_sel));
      cmp(e.tag, "mem_addr_val", mem_addr_val,      e.ma_val);
    end
  end

  function automatic stim_t base();
    stim_t s;
    s = '0;
    s.src_rf = 16'h1111; s.dst_rf = 16'h2222;
    s.el_d = 16'hA001; s.eh_d = 16'hA002; s.wl_d = 16'hA003; s.wh_d = 16'hA004;
    s.m_store = 16'h5151; s.m_addr = 16'h6161;
    s.src_idx = 3'd1; s.dst_idx = 3'd2; s.md_idx = 3'd3; s.ma_idx = 3'd4;
    s.el_idx = 3'd7; s.eh_idx = 3'd7; s.wl_idx = 3'd7; s.wh_idx = 3'd7;
    return s;
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    stim_t s;
    st = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R5 idle: nothing written, every operand falls back.
    s = base();
    drive(s, "R5 idle", 0, 0, 0, 0);

    // All four ports target the source register: priority ladder.
    s = base();
    s.el_we = 1; s.eh_we = 1; s.wl_we = 1; s.wh_we = 1;
    s.el_idx = 3'd1; s.eh_idx = 3'd1; s.wl_idx = 3'd1; s.wh_idx = 3'd1;
    drive(s, "R1 top priority", 1);
    s.el_we = 0; drive(s, "R2 ex high next", 2);
    s.eh_we = 0; drive(s, "R3 wb low next", 3);
    s.wl_we = 0; drive(s, "R4 wb high last", 4);
    // R6: matching indices but every enable off.
    s.wh_we = 0; drive(s, "R6 enables off", 0);

    // R6: enabled port pointing elsewhere, disabled port matching.
    s = base();
    s.el_we = 0; s.el_idx = 3'd1; s.eh_we = 1; s.eh_idx = 3'd5;
    drive(s, "R6 disabled match", 0);

    // R7: src and dst resolve to different ports at once.
    s = base();
    s.el_we = 1; s.el_idx = 3'd2; s.wh_we = 1; s.wh_idx = 3'd1;
    drive(s, "R7 independent", 4, 1);

    // R8: store data low beats high; then high alone; then none.
    s = base();
    s.wl_we = 1; s.wl_idx = 3'd3; s.wh_we = 1; s.wh_idx = 3'd3;
    drive(s, "R8 store low", -1, -1, 1);
    s.wl_we = 0; drive(s, "R8 store high", -1, -1, 2);
    s.wh_we = 0; drive(s, "R8 store path", -1, -1, 0);

    // R9: address uses the source index.
    s = base();
    s.wh_we = 1; s.wh_idx = 3'd4;
    drive(s, "R9 addr high", -1, -1, 0, 2);
    s.wl_we = 1; s.wl_idx = 3'd4;
    drive(s, "R9 addr low", -1, -1, 0, 1);

    // R10: EX/MEM index matches the memory operand, MEM/WB index does not.
    s = base();
    s.el_we = 1; s.el_idx = 3'd3; s.wl_we = 1; s.wl_idx = 3'd6;
    drive(s, "R10 wb index only", -1, -1, 0, 0);
    // MEM/WB matches the source while EX/MEM index differs.
    s = base();
    s.el_we = 1; s.el_idx = 3'd5; s.wl_we = 1; s.wl_idx = 3'd1;
    drive(s, "R10 wb own index", 3);

    // R11: index 0 forwards.
    s = base();
    s.src_idx = 3'd0; s.md_idx = 3'd0; s.el_idx = 3'd0; s.el_we = 1;
    s.wl_idx = 3'd0; s.wl_we = 1;
    drive(s, "R11 index zero", 1, -1, 1);

    // Random sweep over a small index space for frequent collisions.
    for (int n = 0; n < 400; n++) begin
      s = stim_t'({$urandom, $urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom});
      drive(s, "R7 random");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule